// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised set of external interrupt lines, all synchronous to its clock, and turns each one into a pending bit according to its own sense setting. Each line has a polarity, a choice between level and edge detection, and a both-edge option that overrides polarity. Every line also has an enable (mask) bit and a route that names exactly one of several CPU targets. For each target the block reports the lowest-numbered line that is pending, enabled and routed to that target, and raises that target's interrupt output while such a line exists.

Software reaches the block through a 32-bit word-addressed register bus with a combinational read port. Enables change only through separate write-one-to-set and write-one-to-clear words. A command word can force an edge-style pending bit on or off by line number. Software uses this to send inter-processor interrupts and to acknowledge edge interrupts.

Top module: `shared_irq_ctrl`

## Requirements
- R1: After reset every line reads as positive polarity (polarity bit 1), level detect (trigger bit 0), both-edge off, disabled (enable bit 0), routed to target 0. Every target output reads id = NUM_LINES with its interrupt output low.
- R2: A write to the enable-set word (address 32 + i/32) sets the enable of line i for each 1 in bit i%32. A write to the enable-clear word (address 40 + i/32) clears it for each 1. Zero bits leave enables unchanged. Both words read back the current enables.
- R3: For a level line, the pending bit is registered one clock after the input. It is 1 when the input equals the polarity bit (1 = active high, 0 = active low).
- R4: For an edge line without both-edge, polarity 1 latches pending on a rising input and polarity 0 latches it on a falling input. The bit then stays set after the input returns, until a wedge clear.
- R5: With both-edge enabled on an edge line, rising and falling transitions both latch pending, whatever the polarity bit holds.
- R6: The wedge word (address 1) takes a line number in bits [7:0] and an action in bit 31 (1 = set pending, 0 = clear pending). It acts on edge lines in the clock edge that takes the write. Numbers of NUM_LINES or above are ignored, and a wedge set on a level line is ignored. An edge detected in the same cycle as a wedge clear leaves the line pending.
- R7: For each target, the id output is the lowest line number that is pending, enabled and routed to it, or NUM_LINES if there is none. The interrupt output is high exactly when a line is found. Both follow the registered state with no added delay.
- R8: The route of line i is read and written at address 64 + i. A written value below NUM_TARGETS replaces the route, which moves the line off its previous target. A larger value is ignored.
- R9: The configuration word at address 0 reads NUM_LINES/8 - 1 in bits [15:8] and NUM_TARGETS - 1 in bits [3:0], with all other bits 0.
- R10: Polarity, trigger (1 = edge), both-edge and pending (read-only) words sit at bases 8, 16, 24 and 48. Line i is at bit i%32 of base + i/32. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | NUM_LINES | Interrupt source lines, synchronous to clk |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| tgt_irq_o | output | NUM_TARGETS | Per-target interrupt request |
| tgt_id_o | output | NUM_TARGETS*ID_W | Per-target lowest qualifying line number, packed by target |

## Verification
A register write takes effect at the clock edge that samples it. Wedge commands therefore change pending, and the target outputs along with it, in that same edge. An input change or a sense-setting change reaches the pending bit one edge later. The id and interrupt outputs, and reads, are combinational from the registered state. The bench drives every stimulus on a falling edge and lets exactly the needed number of rising edges pass: one for wedge, enable and route writes and for input changes, and one more after a polarity or trigger write. It then compares at the next falling edge, well away from the rising edge.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;

   localparam int BUS_W        = 32;
   localparam int MAX_LINES    = 256;
   localparam int MAX_TARGETS  = 16;

   // word addresses
   localparam int A_CONFIG     = 0;
   localparam int A_WEDGE      = 1;
   localparam int A_POL_BASE   = 8;
   localparam int A_TRIG_BASE  = 16;
   localparam int A_DUAL_BASE  = 24;
   localparam int A_MSET_BASE  = 32;
   localparam int A_MCLR_BASE  = 40;
   localparam int A_PEND_BASE  = 48;
   localparam int A_ROUTE_BASE = 64;

   localparam int WEDGE_ACT_BIT = 31;
   localparam int WEDGE_NUM_W   = 8;

   function automatic int words_for(input int lines);
      return (lines + BUS_W - 1) / BUS_W;
   endfunction

endpackage

// File: rtl/irq_line_sense.sv
module irq_line_sense
   import shared_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic pol_i,
   input  logic edge_i,
   input  logic dual_i,
   input  logic wset_i,
   input  logic wclr_i,
   output logic pend_o
);

   logic prev_q;
   logic pend_q;
   logic active;
   logic rise;
   logic fall;
   logic det;
   logic pend_d;

   assign active = (line_i == pol_i);
   assign rise   = line_i & ~prev_q;
   assign fall   = ~line_i & prev_q;

   always_comb begin
      if (dual_i)
         det = rise | fall;
      else if (pol_i)
         det = rise;
      else
         det = fall;
   end

   always_comb begin
      if (edge_i)
         pend_d = det | wset_i | (pend_q & ~wclr_i);
      else
         pend_d = active;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= line_i;
         pend_q <= pend_d;
      end
   end

   assign pend_o = pend_q;

   // R3: level pending tracks the conditioned input one cycle later
   p_level_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_i) |=> (pend_o == $past(line_i == pol_i)));

   // R4: edge pending holds until a wedge clear
   p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && pend_o && !wclr_i) |=> pend_o);

   // R5: both-edge latches any transition
   p_dual_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && dual_i && (line_i != prev_q)) |=> pend_o);

   // R6: wedge set on an edge line marks it pending
   p_wedge_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && wset_i) |=> pend_o);

endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
   parameter int NUM_LINES = 32,
   parameter int ID_W      = $clog2(NUM_LINES + 1)
) (
   input  logic [NUM_LINES-1:0] cand_i,
   output logic                 found_o,
   output logic [ID_W-1:0]      id_o
);

   always_comb begin
      id_o = ID_W'(NUM_LINES);
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (cand_i[i])
            id_o = ID_W'(i);
      end
   end

   assign found_o = |cand_i;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import shared_irq_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter int NUM_TARGETS = 4,
   parameter int ADDR_W      = 9,
   parameter int TGT_W       = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr_i,
   input  logic                       bus_wr_i,
   input  logic [BUS_W-1:0]           bus_wdata_i,
   output logic [BUS_W-1:0]           bus_rdata_o,
   input  logic [NUM_LINES-1:0]       pend_i,
   output logic [NUM_LINES-1:0]       pol_o,
   output logic [NUM_LINES-1:0]       trig_o,
   output logic [NUM_LINES-1:0]       dual_o,
   output logic [NUM_LINES-1:0]       mask_o,
   output logic [NUM_LINES*TGT_W-1:0] route_o,
   output logic [NUM_LINES-1:0]       wset_o,
   output logic [NUM_LINES-1:0]       wclr_o
);

   localparam int WORDS   = words_for(NUM_LINES);
   localparam int PAD_W   = WORDS * BUS_W;
   localparam int LCODE   = NUM_LINES / 8 - 1;
   localparam int TCODE   = NUM_TARGETS - 1;

   logic [NUM_LINES-1:0] pol_q;
   logic [NUM_LINES-1:0] trig_q;
   logic [NUM_LINES-1:0] dual_q;
   logic [NUM_LINES-1:0] mask_q;
   logic [TGT_W-1:0]     route_q [NUM_LINES];

   logic                 wedge_hit;
   logic [PAD_W-1:0]     pol_pad;
   logic [PAD_W-1:0]     trig_pad;
   logic [PAD_W-1:0]     dual_pad;
   logic [PAD_W-1:0]     mask_pad;
   logic [PAD_W-1:0]     pend_pad;

   // wedge command decode, one comparator per line
   assign wedge_hit = bus_wr_i && (bus_addr_i == ADDR_W'(A_WEDGE));

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_wedge
      logic num_hit;
      assign num_hit   = (bus_wdata_i[WEDGE_NUM_W-1:0] == WEDGE_NUM_W'(g));
      assign wset_o[g] = wedge_hit && num_hit &&  bus_wdata_i[WEDGE_ACT_BIT];
      assign wclr_o[g] = wedge_hit && num_hit && !bus_wdata_i[WEDGE_ACT_BIT];
      assign route_o[g*TGT_W +: TGT_W] = route_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q  <= '1;
         trig_q <= '0;
         dual_q <= '0;
         mask_q <= '0;
         for (int i = 0; i < NUM_LINES; i++)
            route_q[i] <= '0;
      end else if (bus_wr_i) begin
         for (int i = 0; i < NUM_LINES; i++) begin
            if (bus_addr_i == ADDR_W'(A_POL_BASE + i / BUS_W))
               pol_q[i] <= bus_wdata_i[i % BUS_W];
            if (bus_addr_i == ADDR_W'(A_TRIG_BASE + i / BUS_W))
               trig_q[i] <= bus_wdata_i[i % BUS_W];
            if (bus_addr_i == ADDR_W'(A_DUAL_BASE + i / BUS_W))
               dual_q[i] <= bus_wdata_i[i % BUS_W];
            if ((bus_addr_i == ADDR_W'(A_MSET_BASE + i / BUS_W)) && bus_wdata_i[i % BUS_W])
               mask_q[i] <= 1'b1;
            if ((bus_addr_i == ADDR_W'(A_MCLR_BASE + i / BUS_W)) && bus_wdata_i[i % BUS_W])
               mask_q[i] <= 1'b0;
            if ((bus_addr_i == ADDR_W'(A_ROUTE_BASE + i)) &&
                (bus_wdata_i < BUS_W'(NUM_TARGETS)))
               route_q[i] <= bus_wdata_i[TGT_W-1:0];
         end
      end
   end

   assign pol_o  = pol_q;
   assign trig_o = trig_q;
   assign dual_o = dual_q;
   assign mask_o = mask_q;

   // read side
   always_comb begin
      pol_pad  = '0;
      trig_pad = '0;
      dual_pad = '0;
      mask_pad = '0;
      pend_pad = '0;
      pol_pad[NUM_LINES-1:0]  = pol_q;
      trig_pad[NUM_LINES-1:0] = trig_q;
      dual_pad[NUM_LINES-1:0] = dual_q;
      mask_pad[NUM_LINES-1:0] = mask_q;
      pend_pad[NUM_LINES-1:0] = pend_i;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(A_CONFIG)) begin
         bus_rdata_o[15:8] = 8'(LCODE);
         bus_rdata_o[3:0]  = 4'(TCODE);
      end
      for (int w = 0; w < WORDS; w++) begin
         if (bus_addr_i == ADDR_W'(A_POL_BASE + w))
            bus_rdata_o = pol_pad[w*BUS_W +: BUS_W];
         if (bus_addr_i == ADDR_W'(A_TRIG_BASE + w))
            bus_rdata_o = trig_pad[w*BUS_W +: BUS_W];
         if (bus_addr_i == ADDR_W'(A_DUAL_BASE + w))
            bus_rdata_o = dual_pad[w*BUS_W +: BUS_W];
         if (bus_addr_i == ADDR_W'(A_MSET_BASE + w) ||
             bus_addr_i == ADDR_W'(A_MCLR_BASE + w))
            bus_rdata_o = mask_pad[w*BUS_W +: BUS_W];
         if (bus_addr_i == ADDR_W'(A_PEND_BASE + w))
            bus_rdata_o = pend_pad[w*BUS_W +: BUS_W];
      end
      for (int i = 0; i < NUM_LINES; i++) begin
         if (bus_addr_i == ADDR_W'(A_ROUTE_BASE + i))
            bus_rdata_o = BUS_W'(route_q[i]);
      end
   end

   // R2: a one written to the set word enables line 0
   p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == ADDR_W'(A_MSET_BASE) && bus_wdata_i[0]) |=> mask_o[0]);

   // R2: a one written to the clear word disables line 0
   p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == ADDR_W'(A_MCLR_BASE) && bus_wdata_i[0]) |=> !mask_o[0]);

   // R8: an out-of-range route write leaves line 0 where it was
   p_route_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == ADDR_W'(A_ROUTE_BASE) &&
       bus_wdata_i >= BUS_W'(NUM_TARGETS)) |=> $stable(route_o[TGT_W-1:0]));

   // R6: a wedge command touches at most one line
   p_wedge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wset_o | wclr_o));

endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
   import shared_irq_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter int NUM_TARGETS = 4,
   parameter int ADDR_W      = 9,
   localparam int ID_W       = $clog2(NUM_LINES + 1),
   localparam int TGT_W      = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LINES-1:0]        irq_lines_i,
   input  logic [ADDR_W-1:0]           bus_addr_i,
   input  logic                        bus_wr_i,
   input  logic [31:0]                 bus_wdata_i,
   output logic [31:0]                 bus_rdata_o,
   output logic [NUM_TARGETS-1:0]      tgt_irq_o,
   output logic [NUM_TARGETS*ID_W-1:0] tgt_id_o
);

   // elaboration-time parameter checks
   if (NUM_LINES < 8 || NUM_LINES > MAX_LINES || (NUM_LINES % 8) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of 8 between 8 and 256");
   end
   if (NUM_TARGETS < 1 || NUM_TARGETS > MAX_TARGETS) begin : g_bad_targets
      $error("NUM_TARGETS must be between 1 and 16");
   end
   if ((A_ROUTE_BASE + NUM_LINES) > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the route words");
   end

   logic [NUM_LINES-1:0]       pol_w;
   logic [NUM_LINES-1:0]       trig_w;
   logic [NUM_LINES-1:0]       dual_w;
   logic [NUM_LINES-1:0]       mask_w;
   logic [NUM_LINES-1:0]       pend_w;
   logic [NUM_LINES-1:0]       wset_w;
   logic [NUM_LINES-1:0]       wclr_w;
   logic [NUM_LINES*TGT_W-1:0] route_w;

   irq_cfg_regs #(
      .NUM_LINES   (NUM_LINES),
      .NUM_TARGETS (NUM_TARGETS),
      .ADDR_W      (ADDR_W),
      .TGT_W       (TGT_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (bus_addr_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .pend_i      (pend_w),
      .pol_o       (pol_w),
      .trig_o      (trig_w),
      .dual_o      (dual_w),
      .mask_o      (mask_w),
      .route_o     (route_w),
      .wset_o      (wset_w),
      .wclr_o      (wclr_w)
   );

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      irq_line_sense u_sense (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (irq_lines_i[g]),
         .pol_i  (pol_w[g]),
         .edge_i (trig_w[g]),
         .dual_i (dual_w[g]),
         .wset_i (wset_w[g]),
         .wclr_i (wclr_w[g]),
         .pend_o (pend_w[g])
      );
   end

   for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
      logic [NUM_LINES-1:0] cand;
      logic [ID_W-1:0]      pick;
      logic                 found;

      for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
         assign cand[g] = pend_w[g] & mask_w[g] &
                          (route_w[g*TGT_W +: TGT_W] == TGT_W'(t));
      end

      irq_first_pick #(
         .NUM_LINES (NUM_LINES),
         .ID_W      (ID_W)
      ) u_pick (
         .cand_i  (cand),
         .found_o (found),
         .id_o    (pick)
      );

      assign tgt_irq_o[t]              = found;
      assign tgt_id_o[t*ID_W +: ID_W]  = pick;

      // R7: a reported line is pending, enabled and routed here
      p_pick_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
         tgt_irq_o[t] |-> (pick < ID_W'(NUM_LINES)) &&
                          pend_w[pick] && mask_w[pick] &&
                          (route_w[pick*TGT_W +: TGT_W] == TGT_W'(t)));

      // R7: no request means the idle id
      p_idle_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !tgt_irq_o[t] |-> (tgt_id_o[t*ID_W +: ID_W] == ID_W'(NUM_LINES)));
   end

   // R1: a disabled line never raises a target
   p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_w == '0) |-> (tgt_irq_o == '0));

endmodule

// File: tb/shared_irq_ctrl_test.sv
module shared_irq_ctrl_test;

   localparam int NL   = 32;
   localparam int NT   = 4;
   localparam int AW   = 9;
   localparam int IDW  = $clog2(NL + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL-1:0]   lines = '0;
   logic [AW-1:0]   addr = '0;
   logic            wr = 1'b0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NT-1:0]   tirq;
   logic [NT*IDW-1:0] tid;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   shared_irq_ctrl #(.NUM_LINES(NL), .NUM_TARGETS(NT), .ADDR_W(AW)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_lines_i (lines),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .tgt_irq_o   (tirq),
      .tgt_id_o    (tid)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_word(input int a, input logic [31:0] d);
      @(negedge clk);
      addr  = AW'(a);
      wdata = d;
      wr    = 1'b1;
      @(negedge clk);
      wr    = 1'b0;
   endtask

   task automatic rd_word(input int a, output logic [31:0] d);
      @(negedge clk);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   task automatic set_line(input int i, input logic v);
      @(negedge clk);
      lines[i] = v;
      @(negedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic chk_tgt(input int t, input int exp_id, input string tag);
      int a;
      a = int'(tid[t*IDW +: IDW]);
      chk(a == exp_id, tag, a, exp_id);
      chk(tirq[t] == (exp_id != NL), tag, int'(tirq[t]), int'(exp_id != NL));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int t = 0; t < NT; t++) chk_tgt(t, NL, "R1 idle target");
      rd_word(0, d);   chk(d == 32'h0303, "R9 config", d, 32'h0303);
      rd_word(8, d);   chk(d == 32'hFFFF_FFFF, "R1 polarity", d, 32'hFFFF_FFFF);
      rd_word(16, d);  chk(d == 32'h0, "R1 trigger", d, 0);
      rd_word(24, d);  chk(d == 32'h0, "R1 both-edge", d, 0);
      rd_word(32, d);  chk(d == 32'h0, "R1 enables", d, 0);
      rd_word(64 + 31, d); chk(d == 32'h0, "R1 route", d, 0);
      rd_word(2, d);   chk(d == 32'h0, "R10 unmapped", d, 0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr_word(32, 32'h5);
      rd_word(32, d); chk(d == 32'h5, "R2 set", d, 5);
      wr_word(40, 32'h1);
      rd_word(40, d); chk(d == 32'h4, "R2 clear", d, 4);
      wr_word(32, 32'h0);
      wr_word(40, 32'h0);
      rd_word(32, d); chk(d == 32'h4, "R2 zero bits", d, 4);
      wr_word(40, 32'hFFFF_FFFF);
      rd_word(32, d); chk(d == 32'h0, "R2 clear all", d, 0);
   endtask

   task automatic t_level();
      wr_word(32, 32'h8);
      set_line(3, 1'b1);
      chk_tgt(0, 3, "R3 level high");
      chk_tgt(1, NL, "R7 other target quiet");
      set_line(3, 1'b0);
      chk_tgt(0, NL, "R3 level released");
      wr_word(8, 32'hFFFF_FFF7);
      idle();
      chk_tgt(0, 3, "R3 active low");
      wr_word(8, 32'hFFFF_FFFF);
      idle();
      chk_tgt(0, NL, "R3 polarity restored");
      wr_word(40, 32'h8);
   endtask

   task automatic t_edge();
      wr_word(16, 32'h0000_02E4);
      wr_word(32, 32'h20);
      set_line(5, 1'b1);
      chk_tgt(0, 5, "R4 rising latched");
      set_line(5, 1'b0);
      chk_tgt(0, 5, "R4 held after release");
      wr_word(1, 32'h5);
      chk_tgt(0, NL, "R4 wedge clear");
      wr_word(8, 32'hFFFF_FFDF);
      idle();
      set_line(5, 1'b1);
      chk_tgt(0, NL, "R4 rising ignored when negative");
      set_line(5, 1'b0);
      chk_tgt(0, 5, "R4 falling latched");
      wr_word(1, 32'h5);
      chk_tgt(0, NL, "R4 cleared again");
      wr_word(8, 32'hFFFF_FFFF);
      wr_word(40, 32'h20);
   endtask

   task automatic t_dual();
      wr_word(24, 32'h40);
      wr_word(8, 32'hFFFF_FFBF);
      wr_word(32, 32'h40);
      set_line(6, 1'b1);
      chk_tgt(0, 6, "R5 rise with negative polarity");
      wr_word(1, 32'h6);
      chk_tgt(0, NL, "R5 clear");
      set_line(6, 1'b0);
      chk_tgt(0, 6, "R5 fall latched");
      wr_word(1, 32'h6);
      chk_tgt(0, NL, "R5 clear again");
      wr_word(8, 32'hFFFF_FFFF);
      wr_word(40, 32'h40);
   endtask

   task automatic t_wedge();
      logic [31:0] d;
      wr_word(32, 32'h200);
      wr_word(1, 32'h8000_0009);
      chk_tgt(0, 9, "R6 wedge set");
      rd_word(48, d); chk(d == 32'h200, "R6 pending word", d, 32'h200);
      wr_word(1, 32'h8000_0028);
      wr_word(1, 32'h0000_0028);
      rd_word(48, d); chk(d == 32'h200, "R6 out of range ignored", d, 32'h200);
      // clear and a new edge in the same cycle
      @(negedge clk);
      lines[9] = 1'b1;
      addr  = AW'(1);
      wdata = 32'h9;
      wr    = 1'b1;
      @(negedge clk);
      wr    = 1'b0;
      chk_tgt(0, 9, "R6 edge beats clear");
      wr_word(1, 32'h9);
      chk_tgt(0, NL, "R6 wedge clear");
      set_line(9, 1'b0);
      chk_tgt(0, NL, "R6 falling ignored");
      wr_word(40, 32'h200);
      wr_word(32, 32'h8);
      wr_word(1, 32'h8000_0003);
      chk_tgt(0, NL, "R6 level line ignores wedge");
      rd_word(48, d); chk(d == 32'h0, "R6 level pending stays 0", d, 0);
      wr_word(40, 32'h8);
   endtask

   task automatic t_route();
      logic [31:0] d;
      wr_word(1, 32'h8000_0002);
      wr_word(1, 32'h8000_0007);
      wr_word(32, 32'h84);
      chk_tgt(0, 2, "R7 lowest wins");
      wr_word(64 + 2, 32'h1);
      chk_tgt(0, 7, "R8 moved off target 0");
      chk_tgt(1, 2, "R8 moved onto target 1");
      rd_word(64 + 2, d); chk(d == 32'h1, "R8 route readback", d, 1);
      wr_word(64 + 7, 32'h5);
      rd_word(64 + 7, d); chk(d == 32'h0, "R8 bad route ignored", d, 0);
      chk_tgt(0, 7, "R8 still on target 0");
      wr_word(64 + 7, 32'h3);
      chk_tgt(3, 7, "R8 on target 3");
      chk_tgt(0, NL, "R7 none left");
      wr_word(40, 32'h4);
      chk_tgt(1, NL, "R7 disabled line dropped");
      rd_word(48, d); chk(d == 32'h84, "R10 pending bits", d, 32'h84);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_level();
      t_edge();
      t_dual();
      t_wedge();
      t_route();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule